// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a synchronous requester read and write an external asynchronous static RAM that holds 32K bytes. The requester offers one access at a time over a valid/ready handshake: an address, a write flag and a write byte. The block turns each accepted request into a timed strobe sequence on the memory pins. Read data comes back as a single-cycle response pulse.

The memory side has active-low chip-select, write-enable and output-enable strobes and a 15-bit address. The bidirectional data bus is split into a data-out vector, a drive enable for the pad buffer and a data-in vector. Every access passes through four phases in order: idle, setup, active and recovery. In setup the address is settled and all strobes are high. In active the strobes are asserted for a number of cycles. In recovery all strobes are high again. The active length is the memory's timing limit in picoseconds divided by the clock period and rounded up. The clock period and the limits are parameters.

Output-enable stays high for the whole of a write. Because of this, the short write pulse is enough and the memory never drives the bus while the block does.

Top module: `asram_seq`

## Requirements
- R1: While reset is asserted, all three strobes are high (1), the bus drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: `req_ready` is high only in idle, when all strobes are high. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for exactly 5 cycles with the default parameters.
- R3: The memory address is loaded only when a request is accepted. It never changes in a cycle where chip-select is low, or in the cycle that follows one.
- R4: A read holds chip-select and output-enable low, with write-enable high, for ceil(max(address access, read cycle) / clock) cycles. With the defaults this is 3 cycles. The byte on `mem_dq_in` at the edge that ends the last active cycle is presented on `rsp_rdata`, with `rsp_valid` high for exactly one cycle right after that edge (4 cycles after the accepting edge).
- R5: A write holds chip-select and write-enable low for at least 3 cycles with the defaults, and output-enable stays high throughout. The memory stores the byte present on `mem_dq_out` when write-enable rises.
- R6: The bus drive enable is low in the first cycle of write-enable low, and is high from the second active cycle through the first recovery cycle. That gives 2 or more data-setup cycles with the defaults and one cycle of hold. It is never high while output-enable is low, and never high outside a write.
- R7: With the defaults (4000 ps clock, 12 ns access and cycle limits, 9 ns write pulse, 6 ns data setup), both the read strobe and the write strobe last exactly 3 cycles.
- R8: A read returns the byte most recently written to that address, including accesses issued back to back with no idle gap, and at the address extremes 0x0000 and 0x7FFF.
- R9: A `req_valid` raised while the block is busy has no effect. Its address and data never reach the memory unless it is still present when `req_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 15 | Memory address |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Pad drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Byte received from the memory |

## Verification
A memory model returns the inverted byte until the read strobe has been held for the full access time. This exposes a capture taken one cycle early. The model stores only what is on the bus when write-enable rises, which exposes missing data setup or hold. Directed cases cover the following:
- reads of never-written cells;
- the two extreme addresses with bytes 0x00 and 0xFF;
- back-to-back requests that leave no idle cycle;
- requests poked while the block is busy, followed by a read of the poked address.

A seeded random mix of reads and writes over a small address pool then produces frequent read-after-write hits, compared against a shadow copy held by the bench.

// File: rtl/asram_seq.sv
module asram_seq #(
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int CLK_PS    = 4000,
  parameter int T_RC_PS   = 12000,
  parameter int T_AA_PS   = 12000,
  parameter int T_WC_PS   = 12000,
  parameter int T_WP_PS   = 9000,
  parameter int T_DW_PS   = 6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  function automatic int cyc(input int ps);
    return (ps + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int DS_CYC = max2(cyc(T_DW_PS), 1);
  localparam int RD_CYC = max2(max2(cyc(T_AA_PS), cyc(T_RC_PS)), 1);
  localparam int WR_CYC = max2(max2(cyc(T_WP_PS), cyc(T_WC_PS)), DS_CYC + 1);
  localparam int CW     = $clog2(max2(RD_CYC, WR_CYC) + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACT, S_REC} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic [DW-1:0] wd_q;

  wire act  = (st == S_ACT);
  wire last = wr_q ? (cnt == CW'(WR_CYC - 1)) : (cnt == CW'(RD_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          wr_q     <= req_write;
          wd_q     <= req_wdata;
          st       <= S_SETUP;
        end
        S_SETUP: begin
          cnt <= '0;
          st  <= S_ACT;
        end
        S_ACT: if (last) begin
          st <= S_REC;
          if (!wr_q) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_dq_in;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign mem_cs_n   = !act;
  assign mem_we_n   = !(act && wr_q);
  assign mem_oe_n   = !(act && !wr_q);
  assign mem_dq_out = wd_q;
  assign mem_dq_oe  = wr_q && ((act && cnt != '0) || st == S_REC);

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n));
  // R2
  take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R3
  addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> (mem_cs_n && $past(mem_cs_n)));
  // R5
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_cs_n));
  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  // R6
  bus_late_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe);
  // R6
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);
  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/asram_seq_bench.sv
module asram_seq_bench;
  localparam int RD_NEED = 3;
  localparam int WR_NEED = 3;
  localparam int DS_NEED = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out;
  logic [7:0] mem_dq_in = 8'h00;
  logic [14:0] mem_addr;

  always #2 clk = ~clk;

  asram_seq u_asram_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int checks = 0, bad = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] init_byte(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
  endfunction

  logic [7:0] mm [int];
  logic [7:0] shadow [int];

  function automatic logic [7:0] model_rd(input logic [14:0] a);
    return mm.exists(int'(a)) ? mm[int'(a)] : init_byte(a);
  endfunction

  logic p_cs = 1, p_we = 1;
  logic [14:0] p_addr = '0;
  logic [7:0] p_dq = '0;
  int we_len = 0, dq_len = 0, rd_len = 0, last_we_len = 0, last_rd_len = 0;
  logic wr_now, wr_prev, rd_on;

  always @(negedge clk) if (rst_n) begin
    wr_now  = !mem_cs_n && !mem_we_n;
    wr_prev = !p_cs && !p_we;
    rd_on   = !mem_cs_n && mem_we_n && !mem_oe_n;
    if (mem_addr != p_addr)
      chk(mem_cs_n && p_cs, "R3", "address moved under strobe", mem_addr, p_addr);
    if (mem_dq_oe) chk(mem_oe_n, "R6", "bus driven with oe low", mem_oe_n, 1);
    if (!mem_we_n) chk(mem_oe_n, "R5", "oe low during write", mem_oe_n, 1);
    if (wr_now) begin
      we_len++;
      if (mem_dq_oe) dq_len++;
      if (we_len == 1) chk(!mem_dq_oe, "R6", "bus on at we fall", mem_dq_oe, 0);
    end else if (wr_prev) begin
      chk(we_len >= WR_NEED, "R5", "write pulse cycles", we_len, WR_NEED);
      chk(dq_len >= DS_NEED, "R6", "data setup cycles", dq_len, DS_NEED);
      chk(mem_dq_oe, "R6", "data hold after we rise", mem_dq_oe, 1);
      mm[int'(p_addr)] = p_dq;
      last_we_len = we_len;
      we_len = 0;
      dq_len = 0;
    end else if (mem_dq_oe) begin
      chk(1'b0, "R6", "bus driven outside write", 1, 0);
    end
    if (rd_on) rd_len++;
    else if (rd_len != 0) begin
      last_rd_len = rd_len;
      rd_len = 0;
    end
    mem_dq_in = (rd_on && rd_len >= RD_NEED) ? model_rd(mem_addr) : ~model_rd(mem_addr);
    p_cs = mem_cs_n; p_we = mem_we_n; p_addr = mem_addr; p_dq = mem_dq_out;
  end

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      chk(1'b0, "R2", "watchdog expired", cycles, 100000);
      finish_run();
    end
  end

  // Caller is at a negedge; returns at the negedge where ready is back.
  task automatic do_req(input bit w, input logic [14:0] a, input logic [7:0] d,
                        input bit poke);
    logic [7:0] expv;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    expv = shadow.exists(int'(a)) ? shadow[int'(a)] : init_byte(a);
    if (w) shadow[int'(a)] = d;
    req_valid = poke;
    if (poke) begin
      req_write = 1; req_addr = a ^ 15'h1234; req_wdata = ~d;
    end
    for (int k = 1; k <= 5; k++) begin
      chk(!req_ready, "R2", "ready while busy", req_ready, 0);
      if (k == 5) begin
        chk(rsp_valid == !w, "R4", "response pulse", rsp_valid, !w);
        if (!w) chk(rsp_rdata == expv, "R8", "read data", rsp_rdata, expv);
      end else begin
        chk(!rsp_valid, "R4", "early response", rsp_valid, 0);
      end
      if (k == 4) req_valid = 0;
      @(negedge clk);
    end
    chk(req_ready, "R2", "ready after access", req_ready, 1);
    chk(!rsp_valid, "R4", "response longer than one cycle", rsp_valid, 0);
    if (w) chk(last_we_len == WR_NEED, "R7", "write strobe length", last_we_len, WR_NEED);
    else   chk(last_rd_len == RD_NEED, "R7", "read strobe length", last_rd_len, RD_NEED);
  endtask

  initial begin
    logic [14:0] pool [8];
    int seed_dummy;
    pool = '{15'h0000, 15'h7FFF, 15'h0001, 15'h1234, 15'h4000, 15'h2AAA, 15'h5555, 15'h0F0F};
    seed_dummy = $urandom(32'h5EED);
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(mem_cs_n && mem_we_n && mem_oe_n, "R1", "strobes in reset",
        {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(!mem_dq_oe, "R1", "bus released in reset", mem_dq_oe, 0);
    chk(req_ready && !rsp_valid, "R1", "handshake in reset", {req_ready, rsp_valid}, 2'b10);
    rst_n = 1;
    @(negedge clk);
    do_req(0, 15'h0100, 8'h00, 0);            // R8 unwritten cell
    do_req(1, 15'h0000, 8'hFF, 0);            // R5 low extreme
    do_req(1, 15'h7FFF, 8'h00, 0);            // R5 high extreme
    do_req(0, 15'h0000, 8'h00, 0);            // R8
    do_req(0, 15'h7FFF, 8'h00, 0);            // R8
    do_req(1, 15'h0042, 8'hA5, 0);            // back to back, R8
    do_req(0, 15'h0042, 8'h00, 0);
    do_req(1, 15'h0042, 8'h5A, 0);
    do_req(0, 15'h0042, 8'h00, 0);
    // R9: pokes while busy; poked address must keep its old content
    do_req(0, 15'h0300, 8'h77, 1);
    do_req(1, 15'h0301, 8'h66, 1);
    do_req(0, 15'h0300 ^ 15'h1234, 8'h00, 0);
    do_req(0, 15'h0301 ^ 15'h1234, 8'h00, 0);
    for (int i = 0; i < 400; i++) begin
      logic [14:0] a;
      a = ($urandom % 4 == 0) ? 15'($urandom) : pool[$urandom % 8];
      if ($urandom % 3 == 0) @(negedge clk);
      do_req(1'($urandom % 2), a, 8'($urandom), ($urandom % 4 == 0));
    end
    repeat (3) @(negedge clk);
    chk(req_ready && mem_cs_n, "R2", "idle at end", {req_ready, mem_cs_n}, 2'b11);
    finish_run();
  end
endmodule